// File: doc/BRIEF.md
# Command/Indication Two-Frame Change Validator

This block follows the six-bit command/indication (C/I) field that rides in the signalling byte of a time-division frame stream. Each received signalling byte arrives with a one-cycle frame strobe. The block holds a committed C/I value and accepts a new one only when the same new value has arrived in two frames that follow each other, so a single corrupted frame never reaches the line-control logic downstream.

A committed register holds the value in force. A holding register keeps a candidate that has been seen once. A pending flag tells whether the holding register has a candidate that still needs confirming. The committed value drives four control flags (line-monitor enable, tone-generator enable, ringing indication and off-hook control). A one-cycle pulse marks every commit. The two monitor-channel handshake bits in the low end of the byte play no part in any decision.

Top module: `ci_dframe_validator`

## Requirements
- R1: After reset, the committed value is 6'b000000, all four control flags are 0, and the change pulse is 0.
- R2: The C/I field is taken from signalling byte bits 7 down to 2, with byte bit 7 as the field MSB. Byte bits 1 and 0 (monitor-channel handshake bits) have no effect: a byte that differs from the committed value only in those bits changes nothing.
- R3: A single frame with a value that differs from the committed value does not change the committed value.
- R4: When the frame after a candidate carries the same value as the candidate, that value becomes the committed value. It appears on ci_value in the cycle after the clock edge at which the second frame was sampled.
- R5: ci_changed is high for exactly one cycle, the cycle in which ci_value first shows a newly committed value, and it is low in every other cycle.
- R6: When the frame after a candidate matches neither the candidate nor the committed value, it replaces the candidate. This continues for as long as values keep differing, and a later pair of equal frames commits the most recent one.
- R7: When the frame after a candidate equals the committed value, the candidate is dropped. A frame that then repeats the dropped value counts as a fresh first sighting only.
- R8: Cycles with frame_stb low change nothing. Idle cycles between two frames do not break their succession.
- R9: The flags decode the committed value: on_hook_mon = ci_value[3], tone_en = ci_value[2], ring_ind = ci_value[1], off_hook = ci_value[0]. Bits 5 and 4 are reserved and only show in ci_value.
- R10: A frame equal to the committed value, when no candidate is pending, causes no change and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | High for one cycle per received signalling byte |
| sc_byte | input | 8 | Received signalling byte |
| ci_value | output | 6 | Committed C/I value |
| on_hook_mon | output | 1 | On-hook line-monitor enable |
| tone_en | output | 1 | Tone-generator enable |
| ring_ind | output | 1 | Ringing indication |
| off_hook | output | 1 | Off-hook control |
| ci_changed | output | 1 | One-cycle pulse on each commit |

## Verification
A commit and the arrival of the next frame can fall in the same cycle. When frames come on back-to-back strobes, the cycle that shows a new value and the pulse is also the cycle in which the next byte is sampled, either as a fresh candidate or as a repeat of the committed value. The bench provokes this with strobes held high for several cycles in a row (E, E, F, F). It judges each cycle against a queue of expected results from its own model, so a pulse that is lost, doubled or shifted, or a candidate swallowed by the commit, shows up at once.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int SC_W   = 8;
  localparam int CI_W   = 6;
  localparam int CI_LSB = 2;

  typedef struct packed {
    logic lmon;
    logic tone;
    logic ring;
    logic hook;
  } ctrl_flags_t;
endpackage

// File: rtl/ci_field_slice.sv
module ci_field_slice #(
  parameter int SC_W   = 8,
  parameter int CI_W   = 6,
  parameter int CI_LSB = 2
) (
  input  logic [SC_W-1:0] sc_byte,
  output logic [CI_W-1:0] ci_field
);
  localparam int CI_MSB = CI_LSB + CI_W - 1;

  // handshake bits below the field are deliberately discarded
  logic unused_hs;
  assign unused_hs = ^sc_byte[CI_LSB-1:0];

  assign ci_field = sc_byte[CI_MSB:CI_LSB];
endmodule

// File: rtl/ci_confirm_core.sv
module ci_confirm_core #(
  parameter int CI_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic [CI_W-1:0] ci_in,
  output logic [CI_W-1:0] commit_q,
  output logic            changed_q
);
  logic [CI_W-1:0] hold_q;
  logic            pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_q  <= '0;
      hold_q    <= '0;
      pend_q    <= 1'b0;
      changed_q <= 1'b0;
    end else begin
      changed_q <= 1'b0;
      if (stb) begin
        if (pend_q && (ci_in == hold_q)) begin
          commit_q  <= hold_q;
          pend_q    <= 1'b0;
          changed_q <= (hold_q != commit_q);
        end else if (ci_in == commit_q) begin
          pend_q <= 1'b0;
        end else begin
          hold_q <= ci_in;
          pend_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ci_flag_map.sv
module ci_flag_map
  import ci_pkg::*;
#(
  parameter int CI_W = 6
) (
  input  logic [CI_W-1:0] ci,
  output ctrl_flags_t     flags
);
  logic unused_rsv;
  assign unused_rsv = ^ci[CI_W-1:4];

  assign flags.lmon = ci[3];
  assign flags.tone = ci[2];
  assign flags.ring = ci[1];
  assign flags.hook = ci[0];
endmodule

// File: rtl/ci_dframe_validator.sv
module ci_dframe_validator
  import ci_pkg::*;
#(
  parameter int SC_W   = ci_pkg::SC_W,
  parameter int CI_W   = ci_pkg::CI_W,
  parameter int CI_LSB = ci_pkg::CI_LSB
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_stb,
  input  logic [SC_W-1:0] sc_byte,
  output logic [CI_W-1:0] ci_value,
  output logic            on_hook_mon,
  output logic            tone_en,
  output logic            ring_ind,
  output logic            off_hook,
  output logic            ci_changed
);
  logic [CI_W-1:0] ci_field;
  ctrl_flags_t     flags;

  ci_field_slice #(.SC_W(SC_W), .CI_W(CI_W), .CI_LSB(CI_LSB)) u_slice (
    .sc_byte  (sc_byte),
    .ci_field (ci_field)
  );

  ci_confirm_core #(.CI_W(CI_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .stb       (frame_stb),
    .ci_in     (ci_field),
    .commit_q  (ci_value),
    .changed_q (ci_changed)
  );

  ci_flag_map #(.CI_W(CI_W)) u_map (
    .ci    (ci_value),
    .flags (flags)
  );

  assign on_hook_mon = flags.lmon;
  assign tone_en     = flags.tone;
  assign ring_ind    = flags.ring;
  assign off_hook    = flags.hook;
endmodule

// File: rtl/ci_dframe_checker.sv
module ci_dframe_checker #(
  parameter int SC_W   = 8,
  parameter int CI_W   = 6,
  parameter int CI_LSB = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            frame_stb,
  input logic [SC_W-1:0] sc_byte,
  input logic [CI_W-1:0] ci_value,
  input logic            ci_changed
);
  localparam int CI_MSB = CI_LSB + CI_W - 1;

  // R8: no strobe, no change of the committed value
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(ci_value));

  // R5: a pulse always comes with a different value
  a_r5_pulse_has_change: assert property (@(posedge clk) disable iff (rst)
    ci_changed |-> (ci_value != $past(ci_value)));

  // R5: a pulse never lasts two cycles
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
    ci_changed |=> !ci_changed);

  // R4: a commit takes the field of the frame sampled just before
  a_r4_commit_source: assert property (@(posedge clk) disable iff (rst)
    ci_changed |-> ($past(frame_stb) && ($past(sc_byte[CI_MSB:CI_LSB]) == ci_value)));

  // R10: a frame equal to the committed value raises no pulse
  a_r10_same_quiet: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && (sc_byte[CI_MSB:CI_LSB] == ci_value)) |=> !ci_changed);
endmodule

bind ci_dframe_validator ci_dframe_checker #(
  .SC_W(SC_W), .CI_W(CI_W), .CI_LSB(CI_LSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_stb  (frame_stb),
  .sc_byte    (sc_byte),
  .ci_value   (ci_value),
  .ci_changed (ci_changed)
);

// File: tb/sim_ci_dframe_validator.sv
`timescale 1ns/1ps
module sim_ci_dframe_validator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0;
  logic [7:0] sc_byte = 8'h00;
  logic [5:0] ci_value;
  logic       on_hook_mon, tone_en, ring_ind, off_hook, ci_changed;

  always #2.5 clk = ~clk;

  ci_dframe_validator u0 (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .sc_byte(sc_byte),
    .ci_value(ci_value), .on_hook_mon(on_hook_mon), .tone_en(tone_en),
    .ring_ind(ring_ind), .off_hook(off_hook), .ci_changed(ci_changed)
  );

  typedef struct {
    logic [5:0] val;
    logic       pulse;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         checks = 0;
  int         errors = 0;
  logic [5:0] m_commit = '0, m_hold = '0, shown = '0;
  logic       m_pend = 1'b0;
  logic       stb_seen = 1'b0;
  logic       mon_on = 1'b0;
  bit         done = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: one frame, expected result pushed to the scoreboard
  task automatic frame(input logic [7:0] b, input string tag, input int gap);
    exp_t       e;
    logic [5:0] v;
    @(negedge clk);
    frame_stb = 1'b1;
    sc_byte   = b;
    v = b[7:2];
    e.pulse = 1'b0;
    if (m_pend && v == m_hold) begin
      m_commit = m_hold; m_pend = 1'b0; e.pulse = 1'b1;
    end else if (v == m_commit) begin
      m_pend = 1'b0;
    end else begin
      m_hold = v; m_pend = 1'b1;
    end
    e.val = m_commit;
    e.tag = tag;
    q.push_back(e);
    if (gap > 0) begin
      @(negedge clk);
      frame_stb = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    frame_stb = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) stb_seen <= frame_stb;

  // monitor: compare every cycle after reset
  always @(negedge clk) begin
    if (mon_on) begin
      if (stb_seen) begin
        exp_t e;
        if (q.size() == 0) begin
          chk("R4", "queue empty", 1, 0);
        end else begin
          e = q.pop_front();
          shown = e.val;
          chk(e.tag, "ci_value", int'(ci_value), int'(e.val));
          chk("R5", "ci_changed", int'(ci_changed), int'(e.pulse));
          chk("R9", "flags", int'({on_hook_mon, tone_en, ring_ind, off_hook}), int'(e.val[3:0]));
        end
      end else begin
        chk("R8", "idle value", int'(ci_value), int'(shown));
        chk("R5", "idle pulse", int'(ci_changed), 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset value", int'(ci_value), 0);
    chk("R1", "reset flags", int'({on_hook_mon, tone_en, ring_ind, off_hook}), 0);
    chk("R1", "reset pulse", int'(ci_changed), 0);
    mon_on = 1'b1;

    // R10: frame equal to committed value
    frame({6'b000000, 2'b00}, "R10", 2);
    // R3 then R4 with R2: field only, handshake bits differ
    frame({6'b001001, 2'b00}, "R3", 3);
    frame({6'b001001, 2'b11}, "R4", 2);
    // R2: only handshake bits change
    frame({6'b001001, 2'b10}, "R2", 1);
    frame({6'b001001, 2'b01}, "R2", 2);
    // R7: candidate dropped by a frame equal to committed
    frame({6'b000110, 2'b00}, "R7", 1);
    frame({6'b001001, 2'b00}, "R7", 1);
    frame({6'b000110, 2'b00}, "R7", 1);
    frame({6'b000110, 2'b00}, "R7", 2);
    // R6: candidate keeps being replaced
    frame({6'b000001, 2'b00}, "R6", 1);
    frame({6'b000010, 2'b00}, "R6", 1);
    frame({6'b000001, 2'b00}, "R6", 1);
    frame({6'b000100, 2'b00}, "R6", 1);
    frame({6'b000100, 2'b00}, "R6", 2);
    // R5: back-to-back strobes, commit and next frame coincide
    frame({6'b001111, 2'b00}, "R5", 0);
    frame({6'b001111, 2'b00}, "R5", 0);
    frame({6'b110000, 2'b00}, "R5", 0);
    frame({6'b110000, 2'b00}, "R9", 0);
    frame({6'b110000, 2'b00}, "R10", 0);
    frame({6'b001111, 2'b01}, "R3", 0);
    frame({6'b001111, 2'b10}, "R4", 3);
    // R8: long gap between two matching frames
    frame({6'b101010, 2'b00}, "R8", 6);
    frame({6'b101010, 2'b00}, "R8", 3);
    idle(3);
    done = 1'b1;
    mon_on = 1'b0;
    chk("R4", "queue drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule